// File: doc/BRIEF.md
# Host Command Packet Transmitter

This block turns a host-issued command for a display serial link into the word stream a transmit FIFO expects, then runs the send handshake. A request carries a 2-bit virtual channel, a 6-bit data type, a payload length, and three flags: low-power, acknowledge wanted, and read expected. The payload bytes then stream in one per accepted cycle. The block builds a 32-bit header word. The first two payload bytes ride inside this header. The remaining bytes are packed into 32-bit words, least significant byte first.

The block decides whether the packet goes through the small host FIFO or the larger video FIFO, and rejects a packet that fits neither. It asks for a bus turnaround when a reply is due. After the last word it raises a trigger. The trigger stays up until the link reports the packet sent, or until a timeout expires. If the FIFO status reports an underflow or overflow when a request arrives, the block issues a one-cycle FIFO reset before it builds anything. ECC, checksum and the physical layer lie outside this block.

Top module: `hcpt_top`

## Requirements
- R1: The header word (the first word emitted for a packet) carries the data type in bits 5:0 and the virtual channel in bits 7:6, with bits 31:24 zero.
- R2: Payload byte 0 sits in header bits 15:8 and payload byte 1 in bits 23:16; a byte the payload does not have reads as zero there.
- R3: Payload bytes from index 2 on follow the header, four per word, with the lowest index in bits 7:0; the final word is zero-padded, so a packet of length L yields 1 word when L <= 2 and 1 + (L+1)/4 words otherwise.
- R4: `fifo_sel` is 1 (video FIFO) while a packet is in flight when its length exceeds 4*HOST_DEPTH bytes, and 0 (host FIFO) otherwise.
- R5: A request with length above 4*VID_DEPTH bytes raises `err_nospc` for one cycle in the cycle after the request, emits no word and never raises `trigger`; the block then accepts the next request.
- R6: `bta_req` is 1 during the packet when the acknowledge flag or the read flag was given with it.
- R7: `hs_en` is 1 during the packet unless the low-power flag was given.
- R8: `trigger` rises once the last word of the packet has been emitted and falls in the cycle after `tx_done` is seen high, together with a one-cycle `done`; `tx_done` outside a packet has no effect.
- R9: If `tx_done` does not arrive, `trigger` falls and `err_timeout` pulses exactly TIMEOUT_CYC cycles after `trigger` rose.
- R10: With `done`, `byte_count` reads 4 plus the payload length when no turnaround was requested, and 0 when one was.
- R11: When `fifo_fault` is high with an accepted request, `fifo_rst` is high for exactly one cycle before the header word; otherwise `fifo_rst` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken while idle |
| vc | input | 2 | Virtual channel of the request |
| dtype | input | 6 | Data type of the request |
| len | input | LEN_W | Payload length in bytes |
| lp_mode | input | 1 | Send in low-power mode |
| ack_req | input | 1 | Acknowledge wanted |
| read_req | input | 1 | Read data expected |
| fifo_fault | input | 1 | Sticky FIFO underflow/overflow status |
| pl_valid | input | 1 | Payload byte present |
| pl_byte | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte will be taken this cycle if valid |
| fifo_rst | output | 1 | FIFO reset pulse |
| word_valid | output | 1 | FIFO write strobe |
| word_data | output | 32 | FIFO write word |
| fifo_sel | output | 1 | 0 host FIFO, 1 video FIFO |
| hs_en | output | 1 | High-speed transmission |
| bta_req | output | 1 | Bus turnaround after the packet |
| trigger | output | 1 | Transmission in progress |
| tx_done | input | 1 | Link reports the packet sent |
| done | output | 1 | Packet completed |
| byte_count | output | LEN_W+1 | Bytes reported at completion |
| err_nospc | output | 1 | Request too long, rejected |
| err_timeout | output | 1 | Send did not complete in time |

## Verification
The bench builds the block with HOST_DEPTH=4, VID_DEPTH=8 and TIMEOUT_CYC=50. With these values the switch from host to video FIFO falls between 16 and 17 bytes, and rejection falls between 32 and 33 bytes. Both edges therefore sit inside a short payload, and random lengths up to 32 cover them freely. The short timeout lets the missing-`tx_done` case run to expiry and be counted to the exact cycle.

// File: rtl/hcpt_pkg.sv
package hcpt_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FLUSH,
    S_HDR,
    S_BODY,
    S_TRIG
  } hcpt_state_e;

  // Header word: bits 7:6 channel, 5:0 type, payload lanes filled later.
  function automatic logic [31:0] hdr_word(input logic [1:0] ch, input logic [5:0] dt);
    return {24'h0, ch, dt};
  endfunction

  // Write one byte into byte lane `lane` of a word.
  function automatic logic [31:0] put_byte(input logic [31:0] w, input logic [7:0] b,
                                           input logic [1:0] lane);
    logic [31:0] r;
    r = w;
    r[lane*8 +: 8] = b;
    return r;
  endfunction

  // True when `nbytes` fits a FIFO of `depth` 32-bit words.
  function automatic logic fits_fifo(input int unsigned nbytes, input int unsigned depth);
    return nbytes <= 4 * depth;
  endfunction

  // Number of FIFO words a payload of `nbytes` produces, header included.
  function automatic int unsigned words_for_len(input int unsigned nbytes);
    return (nbytes <= 2) ? 1 : 1 + (nbytes + 1) / 4;
  endfunction

endpackage

// File: rtl/hcpt_ctrl.sv
module hcpt_ctrl
  import hcpt_pkg::*;
#(
  parameter int HOST_DEPTH  = 64,
  parameter int VID_DEPTH   = 256,
  parameter int TIMEOUT_CYC = 12_500_000,
  parameter int LEN_W       = 11,
  parameter int CNT_W       = 12,
  parameter int TMO_W       = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             lp_mode,
  input  logic             ack_req,
  input  logic             read_req,
  input  logic             fifo_fault,
  input  logic             pl_valid,
  input  logic             tx_done,
  output logic             pl_ready,
  output logic             accept,
  output logic             load,
  output logic             emit_hdr,
  output logic             emit_body,
  output logic [LEN_W-1:0] idx,
  output logic [LEN_W-1:0] cur_len,
  output logic [1:0]       lane,
  output logic             fifo_rst,
  output logic             fifo_sel,
  output logic             hs_en,
  output logic             bta_req,
  output logic             trigger,
  output logic             done,
  output logic [CNT_W-1:0] byte_count,
  output logic             err_nospc,
  output logic             err_timeout
);

  hcpt_state_e      st;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] idx_q;
  logic [LEN_W-1:0] hdr_need;
  logic [TMO_W-1:0] tcnt;
  logic             lp_q, bta_q;
  logic             too_long, reject, hdr_take, last_byte;

  assign too_long  = !fits_fifo(32'(len), VID_DEPTH);
  assign load      = (st == S_IDLE) && start && !too_long;
  assign reject    = (st == S_IDLE) && start && too_long;
  assign hdr_need  = (len_q > LEN_W'(2)) ? LEN_W'(2) : len_q;
  assign hdr_take  = (st == S_HDR) && (idx_q < hdr_need);
  assign pl_ready  = hdr_take || (st == S_BODY);
  assign accept    = pl_ready && pl_valid;
  assign emit_hdr  = (st == S_HDR) && (idx_q == hdr_need);
  assign last_byte = (idx_q == len_q - LEN_W'(1));
  assign lane      = idx_q[1:0] - 2'd2;
  assign emit_body = (st == S_BODY) && accept && ((lane == 2'd3) || last_byte);

  assign idx      = idx_q;
  assign cur_len  = len_q;
  assign fifo_rst = (st == S_FLUSH);
  assign trigger  = (st == S_TRIG);
  assign fifo_sel = !fits_fifo(32'(len_q), HOST_DEPTH);
  assign hs_en    = !lp_q;
  assign bta_req  = bta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      len_q       <= '0;
      idx_q       <= '0;
      tcnt        <= '0;
      lp_q        <= 1'b0;
      bta_q       <= 1'b0;
      done        <= 1'b0;
      byte_count  <= '0;
      err_nospc   <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      done        <= 1'b0;
      err_timeout <= 1'b0;
      err_nospc   <= reject;
      unique case (st)
        S_IDLE: if (load) begin
          len_q <= len;
          lp_q  <= lp_mode;
          bta_q <= ack_req || read_req;
          idx_q <= '0;
          st    <= fifo_fault ? S_FLUSH : S_HDR;
        end
        S_FLUSH: st <= S_HDR;
        S_HDR: begin
          if (accept) idx_q <= idx_q + LEN_W'(1);
          else if (emit_hdr) begin
            tcnt <= '0;
            st   <= (len_q > LEN_W'(2)) ? S_BODY : S_TRIG;
          end
        end
        S_BODY: if (accept) begin
          idx_q <= idx_q + LEN_W'(1);
          if (last_byte) begin
            tcnt <= '0;
            st   <= S_TRIG;
          end
        end
        S_TRIG: begin
          if (tx_done) begin
            st         <= S_IDLE;
            done       <= 1'b1;
            byte_count <= bta_q ? '0 : CNT_W'(len_q) + CNT_W'(4);
          end else if (tcnt == TMO_W'(TIMEOUT_CYC - 1)) begin
            st          <= S_IDLE;
            err_timeout <= 1'b1;
          end else begin
            tcnt <= tcnt + TMO_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: completion, timeout and rejection are mutually exclusive events
  p_single_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_timeout, err_nospc}));

  // R8: a sent packet drops the trigger and reports completion next cycle
  p_trig_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trigger && tx_done) |=> (!trigger && done));

  // R5: a rejected request leaves the block idle
  p_nospc_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_nospc |-> (!trigger && !pl_ready && !fifo_rst));

  // R9: expiry always takes the trigger down
  p_timeout_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> !trigger);

  // R11: the FIFO reset lasts one cycle and precedes payload intake
  p_flush_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> (!fifo_rst && !trigger));

endmodule

// File: rtl/hcpt_packer.sv
module hcpt_packer
  import hcpt_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       vc,
  input  logic [5:0]       dtype,
  input  logic             accept,
  input  logic [LEN_W-1:0] idx,
  input  logic [1:0]       lane,
  input  logic [7:0]       pl_byte,
  input  logic             emit_hdr,
  input  logic             emit_body,
  output logic             word_valid,
  output logic [31:0]      word_data
);

  logic [31:0] hdr_q;
  logic [31:0] acc_q;
  logic        in_hdr;

  assign in_hdr = (idx < LEN_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q      <= '0;
      acc_q      <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (load) begin
        hdr_q <= hdr_word(vc, dtype);
        acc_q <= '0;
      end else if (accept && in_hdr) begin
        hdr_q <= put_byte(hdr_q, pl_byte, idx[0] ? 2'd2 : 2'd1);
      end else if (accept) begin
        if (emit_body) begin
          word_data  <= put_byte(acc_q, pl_byte, lane);
          word_valid <= 1'b1;
          acc_q      <= '0;
        end else begin
          acc_q <= put_byte(acc_q, pl_byte, lane);
        end
      end
      if (emit_hdr) begin
        word_data  <= hdr_q;
        word_valid <= 1'b1;
      end
    end
  end

  // R1: header and body words never collide in one cycle
  p_emit_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(emit_hdr && emit_body));

endmodule

// File: rtl/hcpt_top.sv
module hcpt_top
  import hcpt_pkg::*;
#(
  parameter int HOST_DEPTH  = 64,
  parameter int VID_DEPTH   = 256,
  parameter int TIMEOUT_CYC = 12_500_000,
  localparam int LEN_W      = $clog2(4 * VID_DEPTH + 1) + 1,
  localparam int CNT_W      = LEN_W + 1,
  localparam int TMO_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       vc,
  input  logic [5:0]       dtype,
  input  logic [LEN_W-1:0] len,
  input  logic             lp_mode,
  input  logic             ack_req,
  input  logic             read_req,
  input  logic             fifo_fault,
  input  logic             pl_valid,
  input  logic [7:0]       pl_byte,
  output logic             pl_ready,
  output logic             fifo_rst,
  output logic             word_valid,
  output logic [31:0]      word_data,
  output logic             fifo_sel,
  output logic             hs_en,
  output logic             bta_req,
  output logic             trigger,
  input  logic             tx_done,
  output logic             done,
  output logic [CNT_W-1:0] byte_count,
  output logic             err_nospc,
  output logic             err_timeout
);

  logic             accept, load, emit_hdr, emit_body;
  logic [LEN_W-1:0] idx, cur_len;
  logic [1:0]       lane;

  hcpt_ctrl #(
    .HOST_DEPTH (HOST_DEPTH),
    .VID_DEPTH  (VID_DEPTH),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .LEN_W      (LEN_W),
    .CNT_W      (CNT_W),
    .TMO_W      (TMO_W)
  ) u_ctrl (
    .clk, .rst_n, .start, .len, .lp_mode, .ack_req, .read_req, .fifo_fault,
    .pl_valid, .tx_done, .pl_ready, .accept, .load, .emit_hdr, .emit_body,
    .idx, .cur_len, .lane, .fifo_rst, .fifo_sel, .hs_en, .bta_req, .trigger,
    .done, .byte_count, .err_nospc, .err_timeout
  );

  hcpt_packer #(.LEN_W(LEN_W)) u_pack (
    .clk, .rst_n, .load, .vc, .dtype, .accept, .idx, .lane, .pl_byte,
    .emit_hdr, .emit_body, .word_valid, .word_data
  );

  // Word tally for the packing check below.
  logic [LEN_W-1:0] wcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wcnt <= '0;
    else if (load)       wcnt <= '0;
    else if (word_valid) wcnt <= wcnt + LEN_W'(1);
  end

  // R3: by the time the trigger rises the full word count has been written
  p_word_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trigger) |-> (32'(wcnt) + 32'(word_valid) == words_for_len(32'(cur_len))));

  // R8: no FIFO write happens while the packet is being sent
  p_no_write_in_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trigger) |-> !word_valid);

endmodule

// File: tb/hcpt_top_tb.sv
module hcpt_top_tb;
  localparam int HD = 4;
  localparam int VD = 8;
  localparam int TO = 50;
  localparam int LW = $clog2(4 * VD + 1) + 1;
  localparam int CW = LW + 1;

  logic clk = 0, rst_n = 0;
  logic start = 0, lp_mode = 0, ack_req = 0, read_req = 0, fifo_fault = 0;
  logic [1:0] vc = 0;
  logic [5:0] dtype = 0;
  logic [LW-1:0] len = 0;
  logic pl_valid = 0, tx_done = 0;
  logic [7:0] pl_byte = 0;
  logic pl_ready, fifo_rst, word_valid, fifo_sel, hs_en, bta_req, trigger;
  logic done, err_nospc, err_timeout;
  logic [31:0] word_data;
  logic [CW-1:0] byte_count;

  int tests = 0, fails = 0;
  logic [7:0]  pay [0:63];
  logic [31:0] got [0:31];
  int got_n = 0, rst_seen = 0;

  always #10 clk = ~clk;

  hcpt_top #(.HOST_DEPTH(HD), .VID_DEPTH(VD), .TIMEOUT_CYC(TO)) u_dut (.*);

  always @(negedge clk) begin
    if (word_valid && got_n < 32) begin got[got_n] = word_data; got_n++; end
    if (fifo_rst) rst_seen++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int j, input int l, input logic [1:0] c,
                                           input logic [5:0] t);
    logic [31:0] w;
    w = 0;
    if (j == 0) begin
      w[7:0] = {c, t};
      if (l > 0) w[15:8]  = pay[0];
      if (l > 1) w[23:16] = pay[1];
    end else begin
      for (int b = 0; b < 4; b++)
        if (2 + 4 * (j - 1) + b < l) w[8*b +: 8] = pay[2 + 4 * (j - 1) + b];
    end
    return w;
  endfunction

  task automatic run_msg(input int l, input logic [1:0] c, input logic [5:0] t,
                         input bit lp, input bit ak, input bit rd, input bit flt,
                         input int hold);
    int k, g, en;
    got_n = 0; rst_seen = 0;
    @(negedge clk);
    start = 1; len = LW'(l); vc = c; dtype = t;
    lp_mode = lp; ack_req = ak; read_req = rd; fifo_fault = flt;
    @(negedge clk);
    start = 0; fifo_fault = 0;
    k = 0; g = 0;
    while (k < l && g < 1000) begin
      if (pl_ready && ($urandom % 4 != 0)) begin
        pl_valid = 1; pl_byte = pay[k]; k++;
      end else pl_valid = 0;
      @(negedge clk); g++;
    end
    pl_valid = 0;
    g = 0;
    while (!trigger && g < 1000) begin @(negedge clk); g++; end
    chk(trigger, "R8 trigger rises", 32'(trigger), 1);
    chk(fifo_sel == (l > 4 * HD), "R4 fifo select", 32'(fifo_sel), 32'(l > 4 * HD));
    chk(hs_en == !lp, "R7 high-speed", 32'(hs_en), 32'(!lp));
    chk(bta_req == (ak || rd), "R6 turnaround", 32'(bta_req), 32'(ak || rd));
    repeat (hold) @(negedge clk);
    chk(trigger, "R8 trigger held", 32'(trigger), 1);
    tx_done = 1;
    @(negedge clk);
    tx_done = 0;
    chk(done && !trigger, "R8 done and release", {done, trigger}, 32'b10);
    chk(byte_count == ((ak || rd) ? 0 : CW'(l + 4)), "R10 byte count",
        32'(byte_count), (ak || rd) ? 0 : l + 4);
    en = (l <= 2) ? 1 : 1 + (l + 1) / 4;
    chk(got_n == en, "R3 word count", got_n, en);
    for (int j = 0; j < en && j < got_n; j++)
      chk(got[j] == exp_word(j, l, c, t), (j == 0) ? "R1 R2 header word" : "R3 body word",
          got[j], exp_word(j, l, c, t));
    chk(rst_seen == (flt ? 1 : 0), "R11 fifo reset", rst_seen, flt ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) pay[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!trigger && !word_valid && !pl_ready && !done, "R8 reset state",
        {trigger, word_valid, pl_ready, done}, 0);

    // directed lengths around header/body and FIFO boundaries
    run_msg(0, 2'd1, 6'h05, 0, 0, 0, 0, 2);
    run_msg(1, 2'd2, 6'h15, 1, 0, 0, 0, 0);
    run_msg(2, 2'd3, 6'h39, 0, 1, 0, 0, 3);
    run_msg(3, 2'd0, 6'h29, 0, 0, 1, 0, 1);
    run_msg(6, 2'd1, 6'h29, 1, 1, 1, 1, 4);
    run_msg(16, 2'd2, 6'h39, 0, 0, 0, 0, 0);
    run_msg(17, 2'd3, 6'h39, 0, 0, 0, 1, 5);
    run_msg(32, 2'd0, 6'h39, 0, 0, 0, 0, TO - 1);

    // R5: rejection above the video FIFO capacity
    got_n = 0;
    @(negedge clk); start = 1; len = LW'(4 * VD + 1);
    @(negedge clk); start = 0;
    chk(err_nospc, "R5 nospc pulse", 32'(err_nospc), 1);
    chk(!pl_ready && !trigger, "R5 stays idle", {pl_ready, trigger}, 0);
    repeat (5) @(negedge clk);
    chk(!err_nospc && !trigger && got_n == 0, "R5 no word no trigger",
        {err_nospc, trigger, 8'(got_n)}, 0);

    // R8: tx_done while idle is ignored
    tx_done = 1; @(negedge clk); tx_done = 0; @(negedge clk);
    chk(!done && !trigger, "R8 idle tx_done ignored", {done, trigger}, 0);

    // R9: timeout when tx_done never comes
    @(negedge clk); start = 1; len = 0; vc = 0; dtype = 6'h01; lp_mode = 0;
    ack_req = 0; read_req = 0;
    @(negedge clk); start = 0;
    n = 0;
    while (!trigger && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (!err_timeout && n < 4 * TO) begin @(negedge clk); n++; end
    chk(n == TO, "R9 timeout cycles", n, TO);
    chk(!trigger && !done, "R9 trigger dropped", {trigger, done}, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      for (int b = 0; b < 64; b++) pay[b] = 8'($urandom);
      run_msg($urandom % 33, 2'($urandom), 6'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), ($urandom % 4) == 0, $urandom % 20);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule